// File: doc/BRIEF.md
# Dual Programmable PLL Ratio Divider

This block turns two clock streams into the comparison pulses a phase detector needs. Both streams arrive as single-cycle tick enables in one system clock domain. The reference stream is the crystal oscillator. The feedback stream is the VCO output. The feedback path divides its ticks by a 16-bit programmed ratio N. The reference path divides by a 14-bit programmed ratio R. A fixed divide-by-4 prescaler can be switched in ahead of it, so the total reference ratio is either 4R or R.

Each path emits a pulse one clock wide after the tick that completes its period. The counters take a new ratio only at terminal count, so a change never shortens or stretches the period in progress. Programmed values below the supported minimum are raised to that minimum. A gating control forces both monitor copies of the pulses low. The phase-detector pulses keep running while the monitors are gated.

Top module: `pll_ratio_divider`

## Requirements
- R1: For an effective N from 28 to 65535, consecutive `fn_pulse_o` pulses are separated by exactly N feedback ticks.
- R2: A programmed N below 28, including 0, behaves as N = 28.
- R3: With `pre_bypass_i` = 1, consecutive `fr_pulse_o` pulses are separated by exactly R reference ticks, for R from 7 to 16383.
- R4: With `pre_bypass_i` = 1, a programmed R below 7, including 0, behaves as R = 7.
- R5: With `pre_bypass_i` = 0, consecutive `fr_pulse_o` pulses are separated by 4 × max(R, 7) reference ticks.
- R6: A ratio written while a period is running takes effect only after the next terminal count. If N changes in the cycle just after a pulse, the next interval still uses the old N and the one after it uses the new N.
- R7: An output pulse lasts exactly one clock cycle. It appears in the cycle right after the clock edge at which the terminal tick was sampled, so no pulse occurs without a tick in the previous cycle.
- R8: When `mon_gate_i` = 1, `fr_mon_o` and `fn_mon_o` are both 0 while `fr_pulse_o` and `fn_pulse_o` keep pulsing. When `mon_gate_i` = 0, each monitor output pulses whenever its phase-detector pulse does.
- R9: While `rst_ni` is low, all four outputs are 0.
- R10: Ratios are counted in ticks, not clock cycles. With a tick on only every third clock, the intervals are still N ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One-cycle enable per oscillator edge |
| vco_tick_i | input | 1 | One-cycle enable per VCO edge |
| n_val_i | input | 16 | Feedback ratio N |
| r_val_i | input | 14 | Reference ratio R |
| pre_bypass_i | input | 1 | 1: skip the divide-by-4 prescaler |
| mon_gate_i | input | 1 | 1: force both monitor outputs low |
| fr_pulse_o | output | 1 | Reference comparison pulse to the phase detector |
| fn_pulse_o | output | 1 | Feedback comparison pulse to the phase detector |
| fr_mon_o | output | 1 | Gated monitor copy of `fr_pulse_o` |
| fn_mon_o | output | 1 | Gated monitor copy of `fn_pulse_o` |

## Verification
The hardest case to reach from the ports is the reload boundary. A new ratio must be presented right after a terminal count, so that an early load would shorten the period already running. The stimulus waits for a feedback pulse and changes N in the very next cycle. It then measures two intervals, expecting the old ratio and then the new one. The largest ratio is run last, after a short period, so that its full 65535-tick interval fits in the run.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  localparam int unsigned N_W_DEF     = 16;
  localparam int unsigned R_W_DEF     = 14;
  localparam int unsigned N_MIN_DEF   = 28;
  localparam int unsigned R_MIN_DEF   = 7;
  localparam int unsigned PRE_DIV_DEF = 4;
endpackage

// File: rtl/pll_prescaler.sv
module pll_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic bypass_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (bypass_i) cnt_q <= '0;
    else if (tick_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = bypass_i ? tick_i : (tick_i && (cnt_q == LAST));
endmodule

// File: rtl/pll_prog_counter.sv
module pll_prog_counter #(
  parameter int unsigned W   = 16,
  parameter int unsigned MIN = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] ratio_i,
  output logic         pulse_o
);
  localparam logic [W-1:0] MIN_V = W'(MIN);

  logic [W-1:0] ratio_eff;
  logic [W-1:0] cnt_q;
  logic         term;

  assign ratio_eff = (ratio_i < MIN_V) ? MIN_V : ratio_i;
  assign term      = (cnt_q == '0);

  // reload sampled only at terminal count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= term ? (ratio_eff - 1'b1) : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= tick_i && term;
  end
endmodule

// File: rtl/pll_mon_gate.sv
module pll_mon_gate #(
  parameter int unsigned NCH = 2
) (
  input  logic [NCH-1:0] pulse_i,
  input  logic           gate_i,
  output logic [NCH-1:0] mon_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign mon_o[g] = pulse_i[g] && !gate_i;
  end
endmodule

// File: rtl/pll_ratio_divider.sv
module pll_ratio_divider #(
  parameter int unsigned N_W     = pll_div_pkg::N_W_DEF,
  parameter int unsigned R_W     = pll_div_pkg::R_W_DEF,
  parameter int unsigned N_MIN   = pll_div_pkg::N_MIN_DEF,
  parameter int unsigned R_MIN   = pll_div_pkg::R_MIN_DEF,
  parameter int unsigned PRE_DIV = pll_div_pkg::PRE_DIV_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ref_tick_i,
  input  logic           vco_tick_i,
  input  logic [N_W-1:0] n_val_i,
  input  logic [R_W-1:0] r_val_i,
  input  logic           pre_bypass_i,
  input  logic           mon_gate_i,
  output logic           fr_pulse_o,
  output logic           fn_pulse_o,
  output logic           fr_mon_o,
  output logic           fn_mon_o
);
  logic       ref_pre_tick;
  logic [1:0] mon;

  pll_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (ref_tick_i),
    .bypass_i(pre_bypass_i),
    .tick_o  (ref_pre_tick)
  );

  pll_prog_counter #(.W(R_W), .MIN(R_MIN)) u_ref_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (ref_pre_tick),
    .ratio_i(r_val_i),
    .pulse_o(fr_pulse_o)
  );

  pll_prog_counter #(.W(N_W), .MIN(N_MIN)) u_fb_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (vco_tick_i),
    .ratio_i(n_val_i),
    .pulse_o(fn_pulse_o)
  );

  pll_mon_gate #(.NCH(2)) u_gate (
    .pulse_i({fn_pulse_o, fr_pulse_o}),
    .gate_i (mon_gate_i),
    .mon_o  (mon)
  );

  assign fr_mon_o = mon[0];
  assign fn_mon_o = mon[1];
endmodule

// File: rtl/pll_ratio_divider_chk.sv
module pll_ratio_divider_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ref_tick_i,
  input logic vco_tick_i,
  input logic mon_gate_i,
  input logic fr_pulse_o,
  input logic fn_pulse_o,
  input logic fr_mon_o,
  input logic fn_mon_o
);
  int unsigned fn_gap_q, fr_gap_q;
  logic        fn_seen_q, fr_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fn_gap_q  <= 0;
      fr_gap_q  <= 0;
      fn_seen_q <= 1'b0;
      fr_seen_q <= 1'b0;
    end else begin
      fn_gap_q <= fn_pulse_o ? 32'(vco_tick_i) : fn_gap_q + 32'(vco_tick_i);
      fr_gap_q <= fr_pulse_o ? 32'(ref_tick_i) : fr_gap_q + 32'(ref_tick_i);
      if (fn_pulse_o) fn_seen_q <= 1'b1;
      if (fr_pulse_o) fr_seen_q <= 1'b1;
    end
  end

  // R7
  fn_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fn_pulse_o |-> $past(vco_tick_i));
  // R7
  fr_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_pulse_o |-> $past(ref_tick_i));
  // R7
  fn_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fn_pulse_o |=> !fn_pulse_o);
  // R8
  mon_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_gate_i |-> (!fn_mon_o && !fr_mon_o));
  // R2
  fn_min_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_pulse_o && fn_seen_q) |-> (fn_gap_q >= 28));
  // R4
  fr_min_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fr_pulse_o && fr_seen_q) |-> (fr_gap_q >= 7));
  // R9
  always_comb begin
    if (!rst_ni) begin
      rst_quiet_chk: assert (!fn_pulse_o && !fr_pulse_o && !fn_mon_o && !fr_mon_o);
    end
  end
endmodule

bind pll_ratio_divider pll_ratio_divider_chk u_chk (.*);

// File: tb/pll_ratio_divider_test.sv
module pll_ratio_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0, vco_tick = 1'b0;
  logic [15:0] n_val = 16'd28;
  logic [13:0] r_val = 14'd7;
  logic        bypass = 1'b1, gate = 1'b0;
  logic        fr_pulse, fn_pulse, fr_mon, fn_mon;

  int checks = 0, errors = 0;
  int fn_cnt = 0, fr_cnt = 0, fn_iv = 0, fr_iv = 0, cyc = 0, gap = 1;
  bit fn_seen, fr_seen, done = 0;

  always #2 clk = ~clk;

  pll_ratio_divider uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .vco_tick_i(vco_tick),
    .n_val_i(n_val), .r_val_i(r_val), .pre_bypass_i(bypass), .mon_gate_i(gate),
    .fr_pulse_o(fr_pulse), .fn_pulse_o(fn_pulse), .fr_mon_o(fr_mon), .fn_mon_o(fn_mon)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (vco_tick) fn_cnt++;
    if (ref_tick) fr_cnt++;
    fn_seen = fn_pulse;
    fr_seen = fr_pulse;
    if (fn_pulse) begin fn_iv = fn_cnt; fn_cnt = 0; end
    if (fr_pulse) begin fr_iv = fr_cnt; fr_cnt = 0; end
    cyc++;
    vco_tick = (cyc % gap) == 0;
    ref_tick = (cyc % gap) == 0;
  endtask

  task automatic next_fn(output int iv);
    do step(); while (!fn_seen);
    iv = fn_iv;
  endtask

  task automatic next_fr(output int iv);
    do step(); while (!fr_seen);
    iv = fr_iv;
  endtask

  task automatic test_fn(int n, int exp, string req);
    int iv;
    n_val = 16'(n);
    next_fn(iv);
    next_fn(iv);
    next_fn(iv);
    chk(iv == exp, req, iv, exp);
  endtask

  task automatic test_fr(int r, bit byp, int exp, string req);
    int iv;
    r_val = 14'(r);
    bypass = byp;
    next_fr(iv);
    next_fr(iv);
    next_fr(iv);
    chk(iv == exp, req, iv, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int iv, np, nm, rp, rm;
    repeat (3) @(negedge clk);
    // R9
    chk(!fr_pulse && !fn_pulse && !fr_mon && !fn_mon, "R9", {fr_pulse, fn_pulse, fr_mon, fn_mon}, 0);
    rst_n = 1'b1;
    // no ticks -> no pulses (R7)
    np = 0;
    for (int i = 0; i < 20; i++) begin step(); if (fn_seen || fr_seen) np++; vco_tick = 0; ref_tick = 0; end
    chk(np == 0, "R7", np, 0);
    cyc = 0;

    test_fn(28, 28, "R1");
    test_fn(29, 29, "R1");
    test_fn(1000, 1000, "R1");
    test_fn(27, 28, "R2");
    test_fn(5, 28, "R2");
    test_fn(0, 28, "R2");

    test_fr(7, 1, 7, "R3");
    test_fr(8, 1, 8, "R3");
    test_fr(500, 1, 500, "R3");
    test_fr(3, 1, 7, "R4");
    test_fr(0, 1, 7, "R4");
    test_fr(7, 0, 28, "R5");
    test_fr(10, 0, 40, "R5");
    test_fr(2, 0, 28, "R5");
    test_fr(300, 0, 1200, "R5");

    // R10: sparse ticks
    gap = 3;
    test_fn(40, 40, "R10");
    test_fr(9, 1, 9, "R10");
    gap = 1;

    // R6: change right after terminal count
    n_val = 16'd50;
    next_fn(iv); next_fn(iv);
    n_val = 16'd60;
    next_fn(iv);
    chk(iv == 50, "R6", iv, 50);
    next_fn(iv);
    chk(iv == 60, "R6", iv, 60);

    // R8 gating
    n_val = 16'd28; r_val = 14'd7; bypass = 1'b1; gate = 1'b1;
    np = 0; nm = 0; rp = 0; rm = 0;
    for (int i = 0; i < 300; i++) begin
      step();
      if (fn_pulse) np++; if (fn_mon) nm++; if (fr_pulse) rp++; if (fr_mon) rm++;
    end
    chk(np > 0 && rp > 0, "R8", np + rp, 1);
    chk(nm == 0 && rm == 0, "R8", nm + rm, 0);
    gate = 1'b0;
    np = 0; nm = 0; rp = 0; rm = 0;
    for (int i = 0; i < 300; i++) begin
      step();
      if (fn_pulse) np++; if (fn_mon) nm++; if (fr_pulse) rp++; if (fr_mon) rm++;
    end
    chk(nm == np && np > 0, "R8", nm, np);
    chk(rm == rp && rp > 0, "R8", rm, rp);

    // R1 maximum ratio, from a short period
    n_val = 16'd65535;
    next_fn(iv);
    next_fn(iv);
    chk(iv == 65535, "R1", iv, 65535);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule